// File: doc/BRIEF.md
# Keyhole Configuration Readout FIFO

This block is the read side of a configuration frame path. A producer hands it configuration data as 128-bit packets, each made of four 32-bit words. The block keeps these words in a deep first-in first-out store. A bus master drains that store one word per read, through a single 4 KiB register window.

The address is not examined inside the window, so every read is a keyhole read of the same queue. The address decode that selects the window sits outside the block, which is why the bus side carries no address. An ingress packet is either stored whole or thrown away whole. Losing a packet, or trying to write to the window, produces a one-cycle error pulse and sets one of two sticky flags. Only reset clears those flags.

Top module: `cfg_readout_keyhole`

## Requirements
- R1: After a synchronous active-low reset the queue is empty. In that state `bus_rvalid`, `bus_rdata`, `err_pulse`, `err_drop_sticky` and `err_write_sticky` are all zero.
- R2: A read (`bus_req`=1, `bus_wr`=0) with a non-empty queue removes the oldest word. That word appears on `bus_rdata` while `bus_rvalid` is high in the cycle after the request. Words leave in the order they arrived, across packets.
- R3: A read with an empty queue returns 0x0000_0000 with `bus_rvalid` high one cycle later, and leaves the queue unchanged.
- R4: A packet (`pkt_valid`=1) is stored when at least four entries are free. Word k of the packet is `pkt_data[32k+31:32k]`, and words are read back in the order k = 0, 1, 2, 3.
- R5: A packet offered with fewer than four free entries is discarded entirely, with no word stored. The next cycle shows a one-cycle `err_pulse`, and `err_drop_sticky` is set.
- R6: A bus write (`bus_req`=1, `bus_wr`=1) leaves the queue unchanged and gives no `bus_rvalid`. It raises `err_pulse` for one cycle and sets `err_write_sticky`.
- R7: A packet and a read may arrive in the same cycle. The space check then uses the occupancy from before that cycle, so a read in that cycle does not make room for the packet. If the packet is accepted, the occupancy rises by three.
- R8: The queue holds exactly DEPTH words (2048 by default). From empty, DEPTH/4 packets are accepted and the next one is dropped.
- R9: The sticky error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Ingress packet offered this cycle |
| pkt_data | input | 128 | Packet, word k in bits 32k+31:32k |
| bus_req | input | 1 | Bus access to the window this cycle |
| bus_wr | input | 1 | Access is a write (unsupported) |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data word |
| err_pulse | output | 1 | One-cycle pulse on drop or illegal write |
| err_drop_sticky | output | 1 | A packet has been dropped since reset |
| err_write_sticky | output | 1 | A bus write has been seen since reset |

## Verification
The hardest condition to reach is a packet arriving in the same cycle as a pop while the queue sits three entries short of full. That needs thousands of entries of setup, and it has no port that shows the occupancy. The bench fills the queue to the brim with 512 packets and confirms that the 513th is dropped. It then pops three words and offers a packet together with a fourth pop, expecting a drop. A lone packet is then expected to fit exactly. The bench drains the whole store afterwards, so the word order shows that no partial packet was ever written.

// File: rtl/kr_pkg.sv
// Shared constants for the keyhole readout FIFO.
// Assumes packets are always a fixed group of four words.
package kr_pkg;
    localparam int KR_PKT_WORDS = 4;
    localparam int KR_WORD_W    = 32;
endpackage

// File: rtl/kr_bank.sv
// One word-wide storage bank. Word k of every packet lives in bank k.
// Assumes one write per cycle and an asynchronous read port; holds no reset
// because emptiness is tracked by the controller pointers.
module kr_bank #(
    parameter int WIDTH = 32,
    parameter int ROWS  = 512,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [ROWS];

    // store one word when the packet is accepted
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // present the addressed word
    assign rdata = mem[raddr];
endmodule

// File: rtl/kr_fifo_ctrl.sv
// Occupancy and pointer control for the packet-in / word-out queue.
// Assumes DEPTH is a power of two and a multiple of the packet size, so the
// write side advances by whole packet rows and both pointers wrap naturally.
module kr_fifo_ctrl
    import kr_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int ROWS  = DEPTH / KR_PKT_WORDS,
    localparam int ROW_W = $clog2(ROWS),
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             drop,
    output logic             empty,
    output logic [ROW_W-1:0] wr_row,
    output logic [PTR_W-1:0] rd_ptr
);
    localparam logic [CW-1:0] FILL_LIMIT = CW'(DEPTH - KR_PKT_WORDS);
    localparam logic [CW-1:0] PKT_INC    = CW'(KR_PKT_WORDS);

    logic [CW-1:0] count;
    logic          room;

    assign room    = (count <= FILL_LIMIT);
    assign empty   = (count == '0);
    assign push_ok = push_req && room;
    assign drop    = push_req && !room;
    assign pop_ok  = pop_req && !empty;

    // occupancy update: add a packet and remove a word in the same cycle if both occur
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + (push_ok ? PKT_INC : '0) - {{(CW-1){1'b0}}, pop_ok};
        end
    end

    // advance the write row per packet and the read pointer per word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_row <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_row <= wr_row + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R8
    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop_req) |=> count == $past(count)); // R5
    AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_req) |=> empty); // R3
    AST_PUSH_POP_NET: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> count == $past(count) + CW'(3)); // R7
endmodule

// File: rtl/cfg_readout_keyhole.sv
// Keyhole readout port: packets of four words go in atomically, and any bus read
// in the window pops one word. Reading when empty yields zero. Writes and
// dropped packets raise a one-cycle pulse and a sticky flag.
// Assumes the address decode of the 4 KiB window is done outside, and only
// full 32-bit accesses reach this block.
module cfg_readout_keyhole
    import kr_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int W     = KR_WORD_W,
    localparam int PKT_W = W * KR_PKT_WORDS,
    localparam int ROWS  = DEPTH / KR_PKT_WORDS,
    localparam int ROW_W = $clog2(ROWS),
    localparam int PTR_W = $clog2(DEPTH),
    localparam int SEL_W = $clog2(KR_PKT_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [PKT_W-1:0] pkt_data,
    input  logic             bus_req,
    input  logic             bus_wr,
    output logic             bus_rvalid,
    output logic [W-1:0]     bus_rdata,
    output logic             err_pulse,
    output logic             err_drop_sticky,
    output logic             err_write_sticky
);
    logic             rd_req, wr_req;
    logic             push_ok, pop_ok, drop, empty;
    logic [ROW_W-1:0] wr_row;
    logic [PTR_W-1:0] rd_ptr;
    logic [W-1:0]     bank_rd [KR_PKT_WORDS];
    logic [SEL_W-1:0] rd_sel;

    assign rd_req = bus_req && !bus_wr;
    assign wr_req = bus_req && bus_wr;
    assign rd_sel = rd_ptr[SEL_W-1:0];

    kr_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_req(pkt_valid),
        .pop_req (rd_req),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .drop    (drop),
        .empty   (empty),
        .wr_row  (wr_row),
        .rd_ptr  (rd_ptr)
    );

    for (genvar b = 0; b < KR_PKT_WORDS; b++) begin : g_bank
        kr_bank #(.WIDTH(W), .ROWS(ROWS)) u_bank (
            .clk  (clk),
            .we   (push_ok),
            .waddr(wr_row),
            .wdata(pkt_data[b*W +: W]),
            .raddr(rd_ptr[PTR_W-1:SEL_W]),
            .rdata(bank_rd[b])
        );
    end

    // register the read response: oldest word, or zero when nothing is queued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_req;
            if (rd_req) bus_rdata <= pop_ok ? bank_rd[rd_sel] : '0;
        end
    end

    // error pulse plus sticky flags that only reset clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse        <= 1'b0;
            err_drop_sticky  <= 1'b0;
            err_write_sticky <= 1'b0;
        end else begin
            err_pulse <= drop || wr_req;
            if (drop)   err_drop_sticky  <= 1'b1;
            if (wr_req) err_write_sticky <= 1'b1;
        end
    end

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid); // R2
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> bus_rdata == '0); // R3
    AST_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (err_pulse && err_write_sticky && !bus_rvalid)); // R6
    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (err_pulse && err_drop_sticky)); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_drop_sticky || err_write_sticky) |=>
        ((err_drop_sticky || !$past(err_drop_sticky)) &&
         (err_write_sticky || !$past(err_write_sticky)))); // R9
endmodule

// File: tb/cfg_readout_keyhole_tb.sv
module cfg_readout_keyhole_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;
    localparam int WD_LIMIT   = 60000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pkt_valid = 1'b0;
    logic [127:0] pkt_data = '0;
    logic         bus_req = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rvalid;
    logic [31:0]  bus_rdata;
    logic         err_pulse, err_drop_sticky, err_write_sticky;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] mdl[$];
    logic m_drop = 1'b0, m_wr = 1'b0;

    cfg_readout_keyhole #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .err_pulse(err_pulse),
        .err_drop_sticky(err_drop_sticky), .err_write_sticky(err_write_sticky)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // packet k word i = {seed, i, 0x5A}
    function automatic logic [127:0] pkt_of(input int seed);
        logic [127:0] p;
        for (int i = 0; i < 4; i++) p[32*i +: 32] = {16'(seed), 8'(i), 8'h5A};
        return p;
    endfunction

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // one cycle of stimulus, expectation from the requirement model, check after the edge
    task automatic step(input logic pv, input int seed, input logic rq,
                        input logic wr, input string rt);
        logic        exp_rv, drop, exp_err;
        logic [31:0] exp_rd;
        logic [127:0] pd;
        pd     = pkt_of(seed);
        exp_rv = rq && !wr;
        exp_rd = (exp_rv && mdl.size() > 0) ? mdl[0] : 32'h0;
        drop   = pv && ((DEPTH - int'(mdl.size())) < 4);
        exp_err = drop || (rq && wr);
        pkt_valid = pv; pkt_data = pd; bus_req = rq; bus_wr = wr;
        @(posedge clk);
        if (exp_rv && mdl.size() > 0) void'(mdl.pop_front());
        if (pv && !drop) for (int i = 0; i < 4; i++) mdl.push_back(pd[32*i +: 32]);
        if (drop) m_drop = 1'b1;
        if (rq && wr) m_wr = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0; bus_req = 1'b0; bus_wr = 1'b0;
        chk(bus_rvalid == exp_rv, rt, "rvalid", 32'(bus_rvalid), 32'(exp_rv));
        if (exp_rv) chk(bus_rdata == exp_rd, rt, "rdata", bus_rdata, exp_rd);
        chk(err_pulse == exp_err, rt, "err_pulse", 32'(err_pulse), 32'(exp_err));
        chk(err_drop_sticky == m_drop, rt, "drop_sticky",
            32'(err_drop_sticky), 32'(m_drop));
        chk(err_write_sticky == m_wr, rt, "write_sticky",
            32'(err_write_sticky), 32'(m_wr));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        mdl.delete(); m_drop = 1'b0; m_wr = 1'b0;
        chk(bus_rvalid == 1'b0, "R1", "rvalid", 32'(bus_rvalid), 0);
        chk(bus_rdata == 32'h0, "R1", "rdata", bus_rdata, 0);
        chk(err_pulse == 1'b0, "R1", "err_pulse", 32'(err_pulse), 0);
        chk(err_drop_sticky == 1'b0, "R9", "drop_sticky", 32'(err_drop_sticky), 0);
        chk(err_write_sticky == 1'b0, "R9", "write_sticky", 32'(err_write_sticky), 0);
        rst_n = 1'b1;
    endtask

    typedef struct packed {
        logic       pv;
        logic       rq;
        logic       wr;
        logic [7:0] seed;
        logic [3:0] req_no;
    } vec_t;

    localparam vec_t VECS [0:13] = '{
        '{1'b0, 1'b1, 1'b0, 8'h00, 4'd3},  // R3 read on empty
        '{1'b1, 1'b0, 1'b0, 8'h11, 4'd4},  // R4 store packet
        '{1'b0, 1'b1, 1'b0, 8'h00, 4'd2},  // R2 word 0
        '{1'b1, 1'b1, 1'b0, 8'h22, 4'd7},  // R7 packet with pop
        '{1'b0, 1'b1, 1'b0, 8'h00, 4'd2},
        '{1'b0, 1'b1, 1'b1, 8'h00, 4'd6},  // R6 write
        '{1'b0, 1'b1, 1'b0, 8'h00, 4'd6},  // R6 queue untouched
        '{1'b1, 1'b1, 1'b1, 8'h33, 4'd6},  // R6 write alongside packet
        '{1'b0, 1'b1, 1'b0, 8'h00, 4'd4},
        '{1'b0, 1'b1, 1'b0, 8'h00, 4'd4},
        '{1'b0, 1'b1, 1'b0, 8'h00, 4'd4},
        '{1'b0, 1'b1, 1'b0, 8'h00, 4'd4},
        '{1'b0, 1'b1, 1'b0, 8'h00, 4'd2},
        '{1'b0, 1'b0, 1'b0, 8'h00, 4'd9}   // R9 stickies hold on idle
    };

    initial begin
        do_reset();
        for (int v = 0; v < 14; v++) begin
            step(VECS[v].pv, int'(VECS[v].seed), VECS[v].rq, VECS[v].wr,
                 $sformatf("R%0d", VECS[v].req_no));
        end
        while (mdl.size() > 0) step(1'b0, 0, 1'b1, 1'b0, "R2");
        step(1'b0, 0, 1'b1, 1'b0, "R3");

        // R8: fill to capacity, then one more packet must be dropped (R5)
        do_reset();
        for (int k = 0; k < DEPTH/4; k++) step(1'b1, 16'h100 + k, 1'b0, 1'b0, "R8");
        step(1'b1, 16'hDEAD, 1'b0, 1'b0, "R5");
        // R7: three short of full, packet with a pop is still refused
        for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b1, 1'b0, "R2");
        step(1'b1, 16'hBEEF, 1'b1, 1'b0, "R7");
        step(1'b1, 16'h7777, 1'b0, 1'b0, "R7");
        step(1'b1, 16'h8888, 1'b0, 1'b0, "R5");
        while (mdl.size() > 0) step(1'b0, 0, 1'b1, 1'b0, "R2");
        step(1'b0, 0, 1'b1, 1'b0, "R3");
        step(1'b0, 0, 1'b1, 1'b1, "R6");

        // R9/R1: reset clears stickies and empties the queue
        step(1'b1, 16'h4242, 1'b0, 1'b0, "R4");
        do_reset();
        step(1'b0, 0, 1'b1, 1'b0, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule